// File: doc/BRIEF.md
# DMA Request Channel Router

This block sits between a chip's peripheral DMA request lines and the request inputs of a DMA engine. Every DMA channel gets its own source selector. The selector picks one peripheral request line or one constant-high source and presents it on that channel's request output. A byte-wide setting register per channel controls the selection. Software reaches these registers through a small synchronous read/write port.

A channel can be off, in which case it drives no request. It can be transparent, so the selected request is passed through unchanged. On the lowest few channels it can also be paced: the selected request reaches the engine only in cycles where an external periodic timer pulses that channel's trigger input. A constant-high source combined with pacing gives exactly one request per timer pulse. A trigger that arrives with no source request pending is lost and is not remembered.

Each channel's request output is registered, so it follows its inputs one clock later. Read data is also registered and appears one clock after the address is presented.

Top module: `dma_req_router`

## Requirements
- R1: After synchronous reset, every setting register reads 0x00 and every channel request output is low.
- R2: The setting register of channel c sits at offset c. Bit 7 enables the channel, bit 6 enables trigger pacing, and bits 5:0 give the source slot. A write is taken on the clock edge where the write strobe is high. The byte written is read back on reg_rdata one clock after its offset is placed on reg_addr.
- R3: A channel whose enable bit is 0 holds its request output low, whatever its source, its trigger and its other bits.
- R4: An enabled channel without effective pacing drives, one clock later, the level of peripheral request line s, where s is the slot and s is in 0..47.
- R5: Slots 60..63 are constant-high sources.
- R6: Slots 48..59 are constant-low sources.
- R7: On channels 0..4 with pacing enabled, the output one clock later is the selected source ANDed with that channel's own trigger input. Triggers of other channels have no effect on it.
- R8: A trigger pulse that arrives while the selected source is low produces no request, either then or later.
- R9: On channels 5 and above, the pacing bit has no effect, and the channel behaves as described in R4.
- R10: Reads of offsets at or above the channel count return 0x00. Writes to those offsets change no setting register.
- R11: Channels are independent. Two channels may select the same slot, and both then carry its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| periph_req | input | NUM_PERIPH (48) | Peripheral request lines, bit i = slot i |
| trig_pulse | input | NUM_TRIG_CH (5) | Periodic trigger pulses, bit c for channel c |
| ch_req | output | NUM_CH (8) | Request output per DMA channel |

## Verification
The hardest situation to reach is the interaction between a paced channel and an isolated trigger pulse. Showing that a pulse passes exactly one request from a constant-high source needs the trigger raised and dropped on consecutive cycles. Showing that a pulse with no pending source is not stored needs that pulse followed by a source request with no trigger. The bench uses cycle-exact pulse sequences on each paced channel to produce both cases. It also checks that the triggers of other channels do not leak into the channel under test. Every slot is swept on every channel with a one-hot and an inverted one-hot request pattern. This covers both levels of every peripheral line, as well as the constant-high and constant-low slot ranges.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  localparam int SLOT_W = 6;
  localparam int CFG_W  = 8;

  typedef struct packed {
    logic              en;
    logic              pace;
    logic [SLOT_W-1:0] slot;
  } dmx_cfg_t;

endpackage

// File: rtl/dmx_cfg_regs.sv
module dmx_cfg_regs
  import dmx_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [CFG_W-1:0]           wdata,
  output logic [CFG_W-1:0]           rdata,
  output dmx_cfg_t [NUM_CH-1:0]      cfg_o
);

  localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(NUM_CH - 1);

  dmx_cfg_t [NUM_CH-1:0] cfg_q;
  logic [CFG_W-1:0]      rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr == ADDR_W'(i)) cfg_q[i] <= dmx_cfg_t'(wdata);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rd_mux = cfg_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign cfg_o = cfg_q;

  // R10: writes beyond the last channel leave every setting untouched
  a_r10_oob_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && addr > LAST_OFS) |=> $stable(cfg_q));

  // R10: reads beyond the last channel return zero
  a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
    (addr > LAST_OFS) |=> (rdata == '0));

endmodule

// File: rtl/dmx_slot_sel.sv
module dmx_slot_sel
  import dmx_pkg::*;
#(
  parameter int NUM_PERIPH = 48,
  parameter int NUM_ALWAYS = 4
) (
  input  logic [SLOT_W-1:0]     slot,
  input  logic [NUM_PERIPH-1:0] periph_req,
  output logic                  src
);

  localparam int SLOT_CNT = 1 << SLOT_W;
  localparam logic [SLOT_W-1:0] ALWAYS_BASE = SLOT_W'(SLOT_CNT - NUM_ALWAYS);

  always_comb begin
    src = 1'b0;
    if (slot >= ALWAYS_BASE) begin
      src = 1'b1;
    end else begin
      for (int i = 0; i < NUM_PERIPH; i++) begin
        if (slot == SLOT_W'(i)) src = periph_req[i];
      end
    end
  end

endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
  import dmx_pkg::*;
#(
  parameter int NUM_PERIPH = 48,
  parameter int NUM_ALWAYS = 4,
  parameter bit HAS_TRIG   = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dmx_cfg_t              cfg_i,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic                  trig_i,
  output logic                  req_o
);

  localparam logic [SLOT_W-1:0] FIRST_GAP = SLOT_W'(NUM_PERIPH);
  localparam logic [SLOT_W-1:0] ALWAYS_BASE = SLOT_W'((1 << SLOT_W) - NUM_ALWAYS);

  logic src;
  logic pace_on;
  logic req_d;

  dmx_slot_sel #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_ALWAYS (NUM_ALWAYS)
  ) u_sel (
    .slot       (cfg_i.slot),
    .periph_req (periph_req),
    .src        (src)
  );

  generate
    if (HAS_TRIG) begin : g_pace
      assign pace_on = cfg_i.pace;
    end else begin : g_nopace
      assign pace_on = 1'b0;
    end
  endgenerate

  always_comb begin
    req_d = 1'b0;
    if (cfg_i.en) req_d = pace_on ? (src & trig_i) : src;
  end

  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= req_d;
  end

  // R3: a disabled channel stays quiet
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !cfg_i.en |=> !req_o);

  // R4, R9: unpaced channels follow the selected source
  a_r4_unpaced_follow: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.en && !pace_on) |=> (req_o == $past(src)));

  // R6: gap slots never request
  a_r6_gap_slot_low: assert property (@(posedge clk) disable iff (rst)
    (cfg_i.slot >= FIRST_GAP && cfg_i.slot < ALWAYS_BASE) |=> !req_o);

  generate
    if (HAS_TRIG) begin : g_pace_chk
      // R7, R8: a paced channel is silent without its trigger
      a_r7_no_trig_no_req: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.en && cfg_i.pace && !trig_i) |=> !req_o);
    end
  endgenerate

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmx_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_TRIG_CH = 5,
  parameter int NUM_PERIPH  = 48,
  parameter int NUM_ALWAYS  = 4,
  parameter int ADDR_W      = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  input  logic [NUM_PERIPH-1:0]  periph_req,
  input  logic [NUM_TRIG_CH-1:0] trig_pulse,
  output logic [NUM_CH-1:0]      ch_req
);

  dmx_cfg_t [NUM_CH-1:0] cfg;

  dmx_cfg_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg_o (cfg)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic trig_c;
      if (c < NUM_TRIG_CH) begin : g_t
        assign trig_c = trig_pulse[c];
      end else begin : g_nt
        assign trig_c = 1'b0;
      end

      dmx_chan #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_ALWAYS (NUM_ALWAYS),
        .HAS_TRIG   (c < NUM_TRIG_CH)
      ) u_ch (
        .clk        (clk),
        .rst        (rst),
        .cfg_i      (cfg[c]),
        .periph_req (periph_req),
        .trig_i     (trig_c),
        .req_o      (ch_req[c])
      );
    end
  endgenerate

  // R1: outputs are low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (ch_req == '0 && reg_rdata == '0));

endmodule

// File: tb/dma_req_router_test.sv
`timescale 1ns/1ps
module dma_req_router_test;

  localparam int NCH = 8;
  localparam int NTR = 5;
  localparam int NP  = 48;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reg_we = 1'b0;
  logic [3:0]     reg_addr = '0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic [NP-1:0]  periph_req = '0;
  logic [NTR-1:0] trig_pulse = '0;
  logic [NCH-1:0] ch_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_req_router uut (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .periph_req (periph_req),
    .trig_pulse (trig_pulse),
    .ch_req     (ch_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic slot_level(input int s, input logic [NP-1:0] p);
    if (s < NP) return p[s];
    if (s >= 60) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset values on every offset
    chk("R1 outputs", 32'(ch_req), 0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk(a < NCH ? "R1 reg" : "R10 read", 32'(d), 0);
    end

    // R2: layout and readback per offset
    for (int c = 0; c < NCH; c++) wr(4'(c), 8'(8'h15 + c * 8'h1d));
    for (int c = 0; c < NCH; c++) begin
      rd(4'(c), d);
      chk("R2 readback", 32'(d), 32'(8'(8'h15 + c * 8'h1d)));
    end

    // R10: out-of-range writes ignored, reads zero
    for (int a = NCH; a < 16; a++) wr(4'(a), 8'hff);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R10 oob", 32'(d), a < NCH ? 32'(8'(8'h15 + a * 8'h1d)) : 0);
    end
    for (int c = 0; c < NCH; c++) wr(4'(c), 8'h00);

    // R3: disabled with always-on source, pacing bit and triggers high
    periph_req = '1; trig_pulse = '1;
    for (int c = 0; c < NCH; c++) wr(4'(c), 8'h7c);
    step();
    chk("R3 disabled", 32'(ch_req), 0);
    for (int c = 0; c < NCH; c++) wr(4'(c), 8'h00);
    trig_pulse = '0;

    // R4 / R5 / R6: exhaustive slot sweep on every channel
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 64; s++) begin
        logic [NP-1:0] oh;
        oh = (s < NP) ? (NP'(1) << s) : '0;
        wr(4'(c), 8'h80 | 8'(s));
        periph_req = oh;
        step();
        chk(s < NP ? "R4 onehot" : (s >= 60 ? "R5 always" : "R6 gap"),
            32'(ch_req), 32'(slot_level(s, oh)) << c);
        periph_req = ~oh;
        step();
        chk(s < NP ? "R4 inverse" : (s >= 60 ? "R5 always" : "R6 gap"),
            32'(ch_req), 32'(slot_level(s, ~oh)) << c);
      end
      wr(4'(c), 8'h00);
    end

    // R7 / R8 / R5: paced channels
    for (int c = 0; c < NTR; c++) begin
      periph_req = '0; periph_req[5] = 1'b1;
      wr(4'(c), 8'hc5);
      trig_pulse = '0;
      step();
      chk("R7 no trigger", 32'(ch_req), 0);
      trig_pulse = ~(NTR'(1) << c);
      step();
      chk("R7 other triggers", 32'(ch_req), 0);
      trig_pulse = NTR'(1) << c;
      step();
      chk("R7 own trigger", 32'(ch_req), 32'(1) << c);
      // R8: trigger with source low is lost
      periph_req = '0;
      step();
      chk("R8 trig no source", 32'(ch_req), 0);
      trig_pulse = '0; periph_req[5] = 1'b1;
      step();
      chk("R8 not stored", 32'(ch_req), 0);
      // R5 with pacing: one request per pulse
      wr(4'(c), 8'hfd);
      trig_pulse = NTR'(1) << c;
      step();
      chk("R5 pulse high", 32'(ch_req), 32'(1) << c);
      trig_pulse = '0;
      step();
      chk("R5 pulse single", 32'(ch_req), 0);
      wr(4'(c), 8'h00);
    end

    // R9: pacing bit ignored above the paced channels
    periph_req = '0; periph_req[7] = 1'b1; trig_pulse = '0;
    for (int c = NTR; c < NCH; c++) wr(4'(c), 8'hc7);
    step();
    chk("R9 pace ignored", 32'(ch_req), 32'((NCH'('1) >> NTR) << NTR));
    for (int c = NTR; c < NCH; c++) wr(4'(c), 8'h00);

    // R11: shared slot on two channels
    wr(4'd0, 8'h83); wr(4'd1, 8'h83);
    periph_req = '0; periph_req[3] = 1'b1;
    step();
    chk("R11 shared", 32'(ch_req), 32'h3);
    periph_req[3] = 1'b0;
    step();
    chk("R11 shared low", 32'(ch_req), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule